// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the instruction address of a pipelined core. It holds the current program counter, a three-deep record of the values the counter held before, and a branch-target register that is filled early and applied later. On every fetch slot the counter moves forward. On that slot the counter can instead take a pending conditional-branch target, an absolute jump address, a relative jump, or a trap vector of zero.

The decoder, register file, memory and condition evaluator sit outside the block. Their results arrive as single-cycle control pins and data words sampled on the rising clock edge. No stream handshake is needed: every request is a plain level that is qualified by the fetch-slot strobe or the target-capture strobe. The block never stalls, so the block applies no back-pressure. The current value, the oldest history value and the link value (current plus one, for store-PC operations) are always readable.

Top module: `pcseq_unit`

## Requirements
- R1: While `rst_n` is low, the current counter, all three history entries and the branch-target register are zero. Straight after reset, `pc_o`=0, `hist_old_o`=0 and `link_o`=1.
- R2: In a cycle where `slot_i` is low, `pc_o` and `hist_old_o` keep their values, and `trap_i`, `take_i`, `jmp_i` and `rel_i` have no effect.
- R3: On a slot cycle with no request asserted, the counter advances by one.
- R4: On a slot cycle with `trap_i` high, the counter becomes 0. This wins over every other request.
- R5: When `tgt_ld_i` is high, the target register loads the counter value of that cycle plus `br_off_i` sign-extended from 12 bits. A slot cycle with `take_i` high (and no trap) copies the target register into the counter.
- R6: A slot cycle with `jmp_i` high, and neither trap nor take, loads `jmp_addr_i` into the counter unchanged, with no increment.
- R7: A slot cycle with `rel_i` high, and no trap, take or jump, sets the counter to its value plus `rel_off_i` sign-extended from 24 bits, with no increment.
- R8: Every slot cycle shifts the history: the old counter goes to entry 1, entry 1 goes to entry 2, entry 2 goes to entry 3, and the old entry 3 is dropped. `hist_old_o` shows entry 3, which is the counter value from three slots back.
- R9: `link_o` always equals `pc_o` plus one, modulo 2^32.
- R10: When target capture and a taken slot happen in the same cycle, the slot uses the target held before that edge. The capture uses the counter value from before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Fetch-slot strobe; the counter updates only when high |
| trap_i | input | 1 | Trap condition true; counter goes to 0 |
| take_i | input | 1 | Branch condition true; apply held target |
| tgt_ld_i | input | 1 | Capture branch target from current counter |
| br_off_i | input | 12 | Signed branch offset |
| jmp_i | input | 1 | Absolute jump load request |
| jmp_addr_i | input | 32 | Absolute jump address |
| rel_i | input | 1 | Unconditional relative jump request |
| rel_off_i | input | 24 | Signed relative offset |
| pc_o | output | 32 | Current counter |
| hist_old_o | output | 32 | Oldest history entry (three slots back) |
| link_o | output | 32 | Current counter plus one |

## Verification
The bench targets the ordering hazards first:
- Requests raised on a non-slot cycle. A design that ignored the slot qualifier would jump early.
- All requests raised together. A wrong priority order would land on the jump address or the target instead of zero.
- Capture and take in the same cycle. A design that bypassed the new target would skip to the wrong address.

Negative offsets at both widths catch a sign extension that zero-fills. Watching the oldest history entry across a trap and through plain increments catches a chain that shifts only on increments, or shifts by the wrong depth.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_REL  = 3'd1,
    SRC_JMP  = 3'd2,
    SRC_TGT  = 3'd3,
    SRC_TRAP = 3'd4
  } pc_src_e;
endpackage

// File: rtl/pcseq_next_sel.sv
module pcseq_next_sel
  import pcseq_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] tgt_pc,
  input  logic [PC_W-1:0] jmp_pc,
  input  logic [PC_W-1:0] rel_ext,
  input  logic            trap_req,
  input  logic            take_req,
  input  logic            jmp_req,
  input  logic            rel_req,
  output pc_src_e         src,
  output logic [PC_W-1:0] nxt_pc
);
  // fixed priority: trap, taken branch, absolute jump, relative jump, step
  always_comb begin
    if (trap_req)      src = SRC_TRAP;
    else if (take_req) src = SRC_TGT;
    else if (jmp_req)  src = SRC_JMP;
    else if (rel_req)  src = SRC_REL;
    else               src = SRC_INC;
  end

  always_comb begin
    unique case (src)
      SRC_TRAP: nxt_pc = '0;
      SRC_TGT:  nxt_pc = tgt_pc;
      SRC_JMP:  nxt_pc = jmp_pc;
      SRC_REL:  nxt_pc = cur_pc + rel_ext;
      default:  nxt_pc = cur_pc + PC_W'(1);
    endcase
  end
endmodule

// File: rtl/pcseq_hist.sv
module pcseq_hist #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic [PC_W-1:0] din,
  output logic [PC_W-1:0] oldest
);
  logic [PC_W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)        stage_q[g] <= '0;
      else if (shift_en) stage_q[g] <= (g == 0) ? din : stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign oldest = stage_q[DEPTH-1];
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PC_W-1:0]  base_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W;
  logic [PC_W-1:0] off_ext;

  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

  always_ff @(posedge clk) begin
    if (!rst_n)    target <= '0;
    else if (load) target <= base_pc + off_ext;
  end
endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int BR_W   = 12,
  parameter int REL_W  = 24,
  parameter int HIST_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_i,
  input  logic             trap_i,
  input  logic             take_i,
  input  logic             tgt_ld_i,
  input  logic [BR_W-1:0]  br_off_i,
  input  logic             jmp_i,
  input  logic [PC_W-1:0]  jmp_addr_i,
  input  logic             rel_i,
  input  logic [REL_W-1:0] rel_off_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  hist_old_o,
  output logic [PC_W-1:0]  link_o
);
  localparam int REL_EXT_W = PC_W - REL_W;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] tgt_q;
  logic [PC_W-1:0] rel_ext;
  pc_src_e         src;

  assign rel_ext = {{REL_EXT_W{rel_off_i[REL_W-1]}}, rel_off_i};

  pcseq_target #(.PC_W(PC_W), .OFF_W(BR_W)) tgt_i (
    .clk(clk), .rst_n(rst_n), .load(tgt_ld_i),
    .base_pc(pc_q), .offset(br_off_i), .target(tgt_q)
  );

  pcseq_next_sel #(.PC_W(PC_W)) sel_i (
    .cur_pc(pc_q), .tgt_pc(tgt_q), .jmp_pc(jmp_addr_i), .rel_ext(rel_ext),
    .trap_req(trap_i), .take_req(take_i), .jmp_req(jmp_i), .rel_req(rel_i),
    .src(src), .nxt_pc(pc_nxt)
  );

  pcseq_hist #(.PC_W(PC_W), .DEPTH(HIST_N)) hist_i (
    .clk(clk), .rst_n(rst_n), .shift_en(slot_i),
    .din(pc_q), .oldest(hist_old_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= '0;
    else if (slot_i) pc_q <= pc_nxt;
  end

  assign pc_o   = pc_q;
  assign link_o = pc_q + PC_W'(1);
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slot_i,
  input logic            trap_i,
  input logic            take_i,
  input logic            jmp_i,
  input logic            rel_i,
  input logic [PC_W-1:0] jmp_addr_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] hist_old_o
);
  a_r2_hold_off_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> ($stable(pc_o) && $stable(hist_old_o)));

  a_r3_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !trap_i && !take_i && !jmp_i && !rel_i) |=> (pc_o == $past(pc_o) + PC_W'(1)));

  a_r4_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && trap_i) |=> (pc_o == '0));

  a_r6_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && jmp_i && !trap_i && !take_i) |=> (pc_o == $past(jmp_addr_i)));
endmodule

bind pcseq_unit pcseq_checker #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .trap_i(trap_i), .take_i(take_i),
  .jmp_i(jmp_i), .rel_i(rel_i), .jmp_addr_i(jmp_addr_i),
  .pc_o(pc_o), .hist_old_o(hist_old_o)
);

// File: tb/pcseq_unit_tb.sv
module pcseq_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_i = 0, trap_i = 0, take_i = 0, tgt_ld_i = 0, jmp_i = 0, rel_i = 0;
  logic [11:0] br_off_i = '0;
  logic [31:0] jmp_addr_i = '0;
  logic [23:0] rel_off_i = '0;
  logic [31:0] pc_o, hist_old_o, link_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] e_pc, e_tgt;
  logic [31:0] e_h [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcseq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .trap_i(trap_i), .take_i(take_i),
    .tgt_ld_i(tgt_ld_i), .br_off_i(br_off_i), .jmp_i(jmp_i), .jmp_addr_i(jmp_addr_i),
    .rel_i(rel_i), .rel_off_i(rel_off_i), .pc_o(pc_o), .hist_old_o(hist_old_o),
    .link_o(link_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    slot_i = 0; trap_i = 0; take_i = 0; tgt_ld_i = 0; jmp_i = 0; rel_i = 0;
    br_off_i = '0; jmp_addr_i = '0; rel_off_i = '0;
  endtask

  // apply the current input values for one edge, update the expected state, compare
  task automatic tick(input string tag);
    logic [31:0] nxt;
    logic [31:0] ntgt;
    nxt  = e_pc;
    ntgt = tgt_ld_i ? e_pc + {{20{br_off_i[11]}}, br_off_i} : e_tgt;
    if (slot_i) begin
      if (trap_i)      nxt = 32'h0;
      else if (take_i) nxt = e_tgt;
      else if (jmp_i)  nxt = jmp_addr_i;
      else if (rel_i)  nxt = e_pc + {{8{rel_off_i[23]}}, rel_off_i};
      else             nxt = e_pc + 32'd1;
      e_h[2] = e_h[1]; e_h[1] = e_h[0]; e_h[0] = e_pc;
    end
    e_pc = nxt; e_tgt = ntgt;
    @(negedge clk);
    chk({tag, " pc"},   pc_o, e_pc);
    chk({tag, " hist"}, hist_old_o, e_h[2]);
    chk({tag, " R9 link"}, link_o, e_pc + 32'd1);
    clr();
  endtask

  task automatic t_reset();
    rst_n = 0; clr();
    repeat (3) @(negedge clk);
    e_pc = 0; e_tgt = 0; e_h[0] = 0; e_h[1] = 0; e_h[2] = 0;
    chk("R1 reset pc", pc_o, 32'h0);
    chk("R1 reset hist", hist_old_o, 32'h0);
    chk("R1 reset link", link_o, 32'h1);
    rst_n = 1;
    // taken slot right after reset must return the cleared target
    slot_i = 1; take_i = 1; tick("R1 reset target");
  endtask

  task automatic t_steps();
    for (int k = 0; k < 5; k++) begin
      slot_i = 1; tick("R3 R8 step");
    end
  endtask

  task automatic t_idle();
    trap_i = 1; jmp_i = 1; jmp_addr_i = 32'hdead_0000; take_i = 1; rel_i = 1; rel_off_i = 24'h10;
    tick("R2 idle requests");
    tick("R2 idle plain");
  endtask

  task automatic t_branch();
    tgt_ld_i = 1; br_off_i = 12'hffc; tick("R5 capture neg");
    slot_i = 1; tick("R5 step between");
    slot_i = 1; take_i = 1; tick("R5 take");
    tgt_ld_i = 1; br_off_i = 12'h7ff; tick("R5 capture pos");
    slot_i = 1; take_i = 1; tick("R5 take pos");
  endtask

  task automatic t_same_cycle();
    tgt_ld_i = 1; br_off_i = 12'h020; tick("R10 preload");
    slot_i = 1; take_i = 1; tgt_ld_i = 1; br_off_i = 12'h100; tick("R10 capture+take");
    slot_i = 1; take_i = 1; tick("R10 new target");
  endtask

  task automatic t_jumps();
    slot_i = 1; jmp_i = 1; jmp_addr_i = 32'h0000_4000; rel_i = 1; rel_off_i = 24'h000123;
    tick("R6 jump over rel");
    slot_i = 1; rel_i = 1; rel_off_i = 24'hfffff0; tick("R7 rel neg");
    slot_i = 1; rel_i = 1; rel_off_i = 24'h7fffff; tick("R7 rel pos");
    slot_i = 1; jmp_i = 1; jmp_addr_i = 32'hffff_fffe; tick("R6 jump high");
    slot_i = 1; tick("R3 wrap");
    slot_i = 1; tick("R3 wrap2");
  endtask

  task automatic t_trap();
    tgt_ld_i = 1; br_off_i = 12'h040; tick("R4 setup");
    slot_i = 1; trap_i = 1; take_i = 1; jmp_i = 1; jmp_addr_i = 32'h1234; rel_i = 1;
    rel_off_i = 24'h55; tick("R4 trap wins");
    for (int k = 0; k < 3; k++) begin
      slot_i = 1; tick("R8 after trap");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_steps();
    t_idle();
    t_branch();
    t_same_cycle();
    t_jumps();
    t_trap();
    t_steps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule